// File: doc/BRIEF.md
# DDR Mode-Register Load Sequencer

This controller-side block programs a DDR SDRAM's mode registers when it receives a start request. It drives the command pins (chip select, row strobe, column strobe, write enable, clock enable, bank address and row address) and issues a fixed chain of load-mode-register commands. It programs the extended register first, setting DLL on/off and output drive strength. If the DLL is being turned on, it then loads the base register with the DLL-reset bit set. It always ends with a load of the base register in normal operating mode, which carries the caller's seven low mode bits (CAS latency, burst type and burst length). Every cycle between two loads is a NOP.

A request is accepted only while all banks are idle and no burst is running. Otherwise the block refuses it, drives nothing and raises a one-cycle flag. When the chain has finished, the block holds a done flag. When the DLL was enabled, it also counts clock cycles with CKE high from the enabling load. It raises read-allowed once the lockout window has passed, and only then.

Top module: `lmr_init_seq`

## Requirements
- R1: While reset is held, CKE is low, the bus shows NOP, and done, busy, refused and read-allowed are all low. CKE goes high on the first clock edge after reset is released.
- R2: The only commands the block emits are a load (chip select, row strobe, column strobe and write enable all low, bus value 4'b0000) and a NOP (chip select low, the other three high, bus value 4'b0111).
- R3: With DLL enable requested, exactly three loads are emitted, in this order. First, BA=01 with address value 2*reduced_drive, so bit 0 = 0 means DLL on and bit 1 = reduced drive. Second, BA=00 with address value 256+mode, which is bit 8 set, bits 7 and 9 and up clear, and bits 6:0 equal to the mode. Third, BA=00 with address value mode.
- R4: With DLL enable not requested, exactly two loads are emitted. The first is BA=01 with address value 2*reduced_drive+1, where bit 0 = 1 means DLL off. The second is BA=00 with address value mode. No DLL-reset load is emitted.
- R5: The first load appears in the cycle after the edge that samples start. Each later load follows the previous one after exactly TMRD NOP cycles (default 2).
- R6: A start request while banks are not idle, or while a burst is active, emits no load. It raises refused for exactly one cycle and leaves done and read-allowed unchanged.
- R7: A start request while busy is ignored. The running chain keeps the settings latched when it was accepted.
- R8: Done rises in the cycle after the final load and stays high until the next accepted start. An accepted start clears it in the cycle of the first load. Done and busy are never high together.
- R9: Read-allowed rises exactly LOCK_CYC cycles (default 200) after the DLL-enabling extended load, provided done is high. It never rises when the DLL was not requested, and it is low from the first load of any new chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the programming chain |
| dll_enable_i | input | 1 | 1 = turn the DLL on and reset it |
| reduced_drive_i | input | 1 | 1 = select reduced output drive |
| mode_bits_i | input | MODE_W (7) | Low mode bits: CAS latency, burst type, burst length |
| banks_idle_i | input | 1 | All banks are precharged |
| burst_active_i | input | 1 | A data burst is in progress |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W (2) | Bank address / register select |
| addr_o | output | ADDR_W (13) | Row address / register value |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | Chain complete |
| refused_o | output | 1 | One-cycle pulse: request refused |
| read_ok_o | output | 1 | DLL lockout elapsed; reads may be issued |

## Verification
The chain is run for all 128 values of the mode bits. The DLL request alternates between runs and the drive select follows a second mode bit, so every pairing of the two flags meets many mode values. This separates the three-load and two-load chains and catches mode bits crossed into the wrong address positions. The load indices, rather than a bare load count, are checked against the TMRD spacing. The read-allowed rise is checked for the exact cycle, which exposes an off-by-one in the lockout counter. Some runs receive a second request with different settings in mid-chain to show it has no effect. Refusals are tried with banks busy and with a burst active, both before any chain and after a completed one, so a refusal that disturbed done or read-allowed would show.

// File: rtl/lmr_seq_pkg.sv
package lmr_seq_pkg;

  typedef enum logic [1:0] {
    STEP_EXT    = 2'd0,
    STEP_DLLRST = 2'd1,
    STEP_NORM   = 2'd2
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_LOAD = cmd_t'(4'b0000);
  localparam cmd_t CMD_NOP  = cmd_t'(4'b0111);

  localparam logic [1:0] SEL_BASE = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b01;

endpackage

// File: rtl/lmr_step_fsm.sv
module lmr_step_fsm
  import lmr_seq_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_i,
  input  logic  with_dll_i,
  output logic  issue_o,
  output step_e step_o,
  output logic  final_o,
  output logic  active_o
);
  localparam int GW = $clog2(TMRD + 1);

  logic          active_q;
  step_e         step_q;
  logic [GW-1:0] gap_q;
  logic          gap_zero;

  assign gap_zero = (gap_q == '0);
  assign issue_o  = go_i | (active_q & gap_zero);
  assign step_o   = go_i ? STEP_EXT : step_q;
  assign final_o  = issue_o & (step_o == STEP_NORM);
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= STEP_EXT;
      gap_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      step_q   <= with_dll_i ? STEP_DLLRST : STEP_NORM;
      gap_q    <= GW'(TMRD);
    end else if (active_q) begin
      if (!gap_zero) begin
        gap_q <= gap_q - 1'b1;
      end else if (step_q == STEP_NORM) begin
        active_q <= 1'b0;
      end else begin
        step_q <= STEP_NORM;
        gap_q  <= GW'(TMRD);
      end
    end
  end
endmodule

// File: rtl/lmr_cmd_enc.sv
module lmr_cmd_enc
  import lmr_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int MODE_W = 7,
  parameter int BA_W   = 2
) (
  input  logic              issue_i,
  input  step_e             step_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dll_off_i,
  input  logic              reduced_i,
  output cmd_t              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int RST_BIT = 8;

  function automatic logic [ADDR_W-1:0] ext_word(input logic off, input logic red);
    logic [ADDR_W-1:0] w;
    w    = '0;
    w[0] = off;
    w[1] = red;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] base_word(input logic rst, input logic [MODE_W-1:0] m);
    logic [ADDR_W-1:0] w;
    w             = '0;
    w[MODE_W-1:0] = m;
    w[RST_BIT]    = rst;
    return w;
  endfunction

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (issue_i) begin
      cmd_o = CMD_LOAD;
      unique case (step_i)
        STEP_EXT: begin
          ba_o   = BA_W'(SEL_EXT);
          addr_o = ext_word(dll_off_i, reduced_i);
        end
        STEP_DLLRST: begin
          ba_o   = BA_W'(SEL_BASE);
          addr_o = base_word(1'b1, mode_i);
        end
        default: begin
          ba_o   = BA_W'(SEL_BASE);
          addr_o = base_word(1'b0, mode_i);
        end
      endcase
    end
  end
endmodule

// File: rtl/lmr_lock_timer.sv
module lmr_lock_timer #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic cke_i,
  output logic full_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == CW'(LOCK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (cke_i && !full_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lmr_init_seq.sv
module lmr_init_seq
  import lmr_seq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int MODE_W   = 7,
  parameter int BA_W     = 2,
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dll_enable_i,
  input  logic              reduced_drive_i,
  input  logic [MODE_W-1:0] mode_bits_i,
  input  logic              banks_idle_i,
  input  logic              burst_active_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              refused_o,
  output logic              read_ok_o
);
  // named internal events
  logic              go_w, refuse_w, issue_w, final_w, active_w, lock_full_w, idle_w;
  step_e             step_w;
  cmd_t              cmd_w, cmd_q;
  logic [BA_W-1:0]   ba_w, ba_q;
  logic [ADDR_W-1:0] addr_w, addr_q;
  logic [MODE_W-1:0] mode_q, mode_sel;
  logic              off_q, red_q, off_sel, red_sel;
  logic              cke_q, dll_on_q, last_q, done_q, refused_q;

  assign idle_w   = ~(active_w | last_q);
  assign go_w     = start_i & idle_w & cke_q & banks_idle_i & ~burst_active_i;
  assign refuse_w = start_i & idle_w & cke_q & ~(banks_idle_i & ~burst_active_i);

  assign mode_sel = go_w ? mode_bits_i      : mode_q;
  assign off_sel  = go_w ? ~dll_enable_i    : off_q;
  assign red_sel  = go_w ? reduced_drive_i  : red_q;

  lmr_step_fsm #(.TMRD(TMRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go_w), .with_dll_i(dll_enable_i),
    .issue_o(issue_w), .step_o(step_w), .final_o(final_w), .active_o(active_w)
  );

  lmr_cmd_enc #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .BA_W(BA_W)) u_enc (
    .issue_i(issue_w), .step_i(step_w), .mode_i(mode_sel),
    .dll_off_i(off_sel), .reduced_i(red_sel),
    .cmd_o(cmd_w), .ba_o(ba_w), .addr_o(addr_w)
  );

  lmr_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .clear_i(go_w & dll_enable_i),
    .cke_i(cke_q), .full_o(lock_full_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      mode_q    <= '0;
      off_q     <= 1'b0;
      red_q     <= 1'b0;
      dll_on_q  <= 1'b0;
      last_q    <= 1'b0;
      done_q    <= 1'b0;
      refused_q <= 1'b0;
    end else begin
      cke_q     <= 1'b1;
      cmd_q     <= cmd_w;
      ba_q      <= ba_w;
      addr_q    <= addr_w;
      refused_q <= refuse_w;
      last_q    <= final_w;
      if (go_w) begin
        mode_q   <= mode_bits_i;
        off_q    <= ~dll_enable_i;
        red_q    <= reduced_drive_i;
        dll_on_q <= dll_enable_i;
        done_q   <= 1'b0;
      end else if (last_q) begin
        done_q   <= 1'b1;
      end
    end
  end

  assign cke_o     = cke_q;
  assign cs_n_o    = cmd_q.cs_n;
  assign ras_n_o   = cmd_q.ras_n;
  assign cas_n_o   = cmd_q.cas_n;
  assign we_n_o    = cmd_q.we_n;
  assign ba_o      = ba_q;
  assign addr_o    = addr_q;
  assign busy_o    = ~idle_w;
  assign done_o    = done_q;
  assign refused_o = refused_q;
  assign read_ok_o = dll_on_q & lock_full_w & done_q;
endmodule

// File: rtl/lmr_init_seq_chk.sv
module lmr_init_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              refused_o,
  input logic              read_ok_o
);
  localparam int SW = $clog2(TMRD + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic          is_load, is_nop, base_sel, ext_sel;
  logic          seen_q, prev_ext_on_q, prev_rst_q;
  logic [SW-1:0] since_q;
  logic [LW-1:0] lock_q;

  assign is_load  = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
  assign is_nop   = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);
  assign base_sel = (ba_o == BA_W'(0));
  assign ext_sel  = (ba_o == BA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q        <= 1'b0;
      prev_ext_on_q <= 1'b0;
      prev_rst_q    <= 1'b0;
      since_q       <= '0;
      lock_q        <= '0;
    end else begin
      if (is_load) begin
        seen_q        <= 1'b1;
        prev_ext_on_q <= ext_sel & ~addr_o[0];
        prev_rst_q    <= base_sel & addr_o[8];
        since_q       <= '0;
      end else if (since_q != SW'(TMRD)) begin
        since_q <= since_q + 1'b1;
      end
      if (is_load && ext_sel && !addr_o[0]) lock_q <= LW'(1);
      else if (lock_q != LW'(LOCK_CYC))     lock_q <= lock_q + 1'b1;
    end
  end

  // R1
  cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> cke_o);
  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) is_load || is_nop);
  // R3
  ba_range_chk: assert property (@(posedge clk) disable iff (!rst_n) is_load |-> (base_sel || ext_sel));
  // R3
  base_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && base_sel) |-> (addr_o[ADDR_W-1:9] == '0 && !addr_o[7]));
  // R3
  ext_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && ext_sel) |-> (addr_o[ADDR_W-1:2] == '0));
  // R3
  dll_reset_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && prev_ext_on_q) |-> (base_sel && addr_o[8]));
  // R3
  normal_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && prev_rst_q) |-> (base_sel && !addr_o[8]));
  // R5
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && seen_q) |-> (since_q == SW'(TMRD)));
  // R6
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) refused_o |-> is_nop);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o);
  // R9
  read_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok_o |-> (done_o && lock_q == LW'(LOCK_CYC)));
endmodule

bind lmr_init_seq lmr_init_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD(TMRD), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o),
  .busy_o(busy_o), .done_o(done_o), .refused_o(refused_o), .read_ok_o(read_ok_o)
);

// File: tb/lmr_init_seq_bench.sv
module lmr_init_seq_bench;
  localparam int T  = 2;
  localparam int LK = 200;
  localparam int AW = 13;
  localparam int MW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, dll_enable_i, reduced_drive_i, banks_idle_i, burst_active_i;
  logic [MW-1:0] mode_bits_i;
  logic          cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]    ba_o;
  logic [AW-1:0] addr_o;
  logic          busy_o, done_o, refused_o, read_ok_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lmr_init_seq #(.ADDR_W(AW), .MODE_W(MW), .BA_W(2), .TMRD(T), .LOCK_CYC(LK)) u_lmr_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dll_enable_i(dll_enable_i),
    .reduced_drive_i(reduced_drive_i), .mode_bits_i(mode_bits_i),
    .banks_idle_i(banks_idle_i), .burst_active_i(burst_active_i),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
    .refused_o(refused_o), .read_ok_o(read_ok_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] bus();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  // expected register words, restated arithmetically
  function automatic int ext_val(input bit dll, input bit red);
    return (red ? 2 : 0) + (dll ? 0 : 1);
  endfunction

  task automatic run_seq(input bit dll, input bit red, input int mode, input bit poke);
    logic [1:0]    lba[4];
    logic [AW-1:0] lad[4];
    int            lix[4];
    int            nl = 0, done_at = -1, rok_at = -1, n_exp, win, last;
    start_i = 1'b1; dll_enable_i = dll; reduced_drive_i = red;
    mode_bits_i = MW'(mode); banks_idle_i = 1'b1; burst_active_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    win = dll ? LK + 4 : 2 * T + 6;
    for (int idx = 0; idx < win; idx++) begin
      if (bus() == 4'b0000) begin
        if (nl < 4) begin lba[nl] = ba_o; lad[nl] = addr_o; lix[nl] = idx; end
        nl++;
      end else if (bus() != 4'b0111) begin
        check("R2", "illegal command", 32'(bus()), 32'h7);
      end
      if (idx == 0) begin
        check("R8", "done cleared at first load", 32'(done_o), 0);
        check("R9", "read_ok cleared at first load", 32'(read_ok_o), 0);
        check("R7", "busy after accept", 32'(busy_o), 1);
      end
      if (done_o && done_at < 0) done_at = idx;
      if (read_ok_o && rok_at < 0) rok_at = idx;
      if (poke && idx == 1) begin
        start_i = 1'b1; dll_enable_i = ~dll; reduced_drive_i = ~red; mode_bits_i = ~MW'(mode);
      end
      if (poke && idx == 2) start_i = 1'b0;
      @(negedge clk);
    end
    n_exp = dll ? 3 : 2;
    check(dll ? "R3" : "R4", "load count", 32'(nl), 32'(n_exp));
    if (poke) check("R7", "load count with mid-chain request", 32'(nl), 32'(n_exp));
    if (nl == n_exp) begin
      check("R5", "first load index", 32'(lix[0]), 0);
      check("R5", "second load index", 32'(lix[1]), 32'(T + 1));
      check(dll ? "R3" : "R4", "ext BA", 32'(lba[0]), 1);
      check(dll ? "R3" : "R4", "ext word", 32'(lad[0]), 32'(ext_val(dll, red)));
      if (dll) begin
        check("R5", "third load index", 32'(lix[2]), 32'(2 * T + 2));
        check("R3", "dll-reset BA", 32'(lba[1]), 0);
        check("R3", "dll-reset word", 32'(lad[1]), 32'(256 + mode));
        check("R3", "normal BA", 32'(lba[2]), 0);
        check("R3", "normal word", 32'(lad[2]), 32'(mode));
        if (poke) check("R7", "latched mode kept", 32'(lad[2]), 32'(mode));
      end else begin
        check("R4", "normal BA", 32'(lba[1]), 0);
        check("R4", "normal word", 32'(lad[1]), 32'(mode));
      end
      last = lix[n_exp - 1];
      check("R8", "done rise index", 32'(done_at), 32'(last + 1));
    end
    check("R8", "done held", 32'(done_o), 1);
    check("R9", "read_ok rise index", 32'(rok_at), dll ? 32'(LK) : 32'hFFFFFFFF);
    check("R9", "read_ok level at end", 32'(read_ok_o), dll ? 1 : 0);
  endtask

  task automatic refuse_try(input bit idle, input bit burst);
    logic d0, r0;
    d0 = done_o; r0 = read_ok_o;
    start_i = 1'b1; banks_idle_i = idle; burst_active_i = burst; mode_bits_i = 7'h55;
    dll_enable_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R6", "refused pulse", 32'(refused_o), 1);
    check("R6", "no load on refusal", 32'(bus()), 32'h7);
    check("R6", "not busy", 32'(busy_o), 0);
    @(negedge clk);
    check("R6", "refused one cycle", 32'(refused_o), 0);
    check("R6", "still no load", 32'(bus()), 32'h7);
    check("R6", "done unchanged", 32'(done_o), 32'(d0));
    check("R6", "read_ok unchanged", 32'(read_ok_o), 32'(r0));
    banks_idle_i = 1'b1; burst_active_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dll_enable_i = 1'b0; reduced_drive_i = 1'b0;
    mode_bits_i = '0; banks_idle_i = 1'b1; burst_active_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "cke in reset", 32'(cke_o), 0);
    check("R1", "bus in reset", 32'(bus()), 32'h7);
    check("R1", "flags in reset", 32'({busy_o, done_o, refused_o, read_ok_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cke after reset", 32'(cke_o), 1);
    check("R1", "bus idle after reset", 32'(bus()), 32'h7);
    @(negedge clk);
    refuse_try(1'b0, 1'b0);
    refuse_try(1'b1, 1'b1);
    for (int m = 0; m < 128; m++) begin
      run_seq((m % 2) == 0, ((m >> 1) % 2) == 1, m, (m % 16) == 5);
      if (m == 0 || m == 1) begin
        refuse_try(1'b0, 1'b0);
        refuse_try(1'b1, 1'b1);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule